// File: doc/BRIEF.md
# External Interrupt Line Controller

This block collects up to 224 external interrupt lines. It turns each one into a pending status bit and merges the pending lines into one interrupt output for the primary processing domain. Each line first passes through a synchroniser. It can then be configured as rising-edge, falling-edge, active-high level or active-low level triggered, and it can also be forced by software.

Software works through a simple 32-bit word-addressed read/write port. Every line has six per-line bits: pending, mask, sensitivity, polarity, software trigger and domain-0 enable. The lines are packed 32 to a word, and each group of words sits at its own location. The mask, sensitivity, software-trigger and polarity bits cannot be written directly. They are changed through write-one-to-set and write-one-to-clear aliases, so software never needs a read-modify-write. A pending bit is cleared by writing a one to the matching acknowledge location.

A typical use is firmware that polls a line: it reads the status word, then acknowledges the bit it found. A second use is interrupt-driven operation: firmware picks the trigger type, routes the line to domain 0, and then unmasks it.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset every mask bit of an implemented line reads 1. Pending, sensitivity, polarity, software-trigger and domain-0 enable bits read 0, and `irq_o` is low.
- R2: Line n is held at bit n%32 of word n/32 in every group. Word w of group g is at byte address g*0x40 + w*4, with g coded as: 0 status, 1 acknowledge, 2 mask, 3 mask-set, 4 mask-clear, 5 sensitivity, 6 sensitivity-set, 7 sensitivity-clear, 8 soft, 9 soft-set, 10 soft-clear, 11 reserved, 12 polarity, 13 polarity-set, 14 polarity-clear, 15 reserved. Domain-0 enable word w is at 0x400 + w*4. Only word-aligned addresses are decoded.
- R3: A write to a set alias (group 3, 6, 9 or 13) sets each underlying bit whose data bit is 1. A data bit of 0 leaves its bit unchanged.
- R4: A write to a clear alias (group 4, 7, 10 or 14) clears each underlying bit whose data bit is 1. A data bit of 0 leaves its bit unchanged.
- R5: A read returns the addressed word on `rdata_o` one clock after `rd_en_i`. Mask, sensitivity, soft, polarity, status and domain-0 enable words return their stored bits. Set, clear, acknowledge and reserved groups return 0, and so do 0x41C and the region from 0x420 upward. Writes to the status word and to the mask, sensitivity, soft and polarity words themselves are ignored. Writes to 0x41C and to the region from 0x420 upward are also ignored.
- R6: With sensitivity 0 the line is edge triggered. Polarity 1 records a rising edge and polarity 0 records a falling edge. The opposite edge records nothing.
- R7: With sensitivity 1 the line is level triggered: polarity 1 means active high and polarity 0 means active low. While the active level is present, the pending bit is set again on every cycle, so an acknowledge takes lasting effect only once the level goes away.
- R8: Writing 1 to an acknowledge bit clears that pending bit, unless the line triggers in the same cycle. Writing 0 has no effect. A pending bit never clears any other way, so an edge stays recorded until it is acknowledged.
- R9: A software-trigger bit that is set acts as an active trigger for its line, whatever the input level.
- R10: Pending is recorded whatever the mask says. `irq_o` is the OR over all lines of pending AND NOT mask AND domain-0 enable.
- R11: A change on `line_i` that meets the configured trigger makes `irq_o` rise after the third rising clock edge, and not before it. This assumes the line is routed and unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | NUM_LINES | External interrupt lines, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_en_i |
| irq_o | output | 1 | Domain-0 interrupt request |

## Verification
Some properties are checked on every cycle, whatever the stimulus. A set alias always leaves its bits set and a clear alias always leaves its bits cleared. A pending bit drops only under an acknowledge, and an acknowledge of a non-triggering line always clears it. `irq_o` stays low while no line is routed to domain 0. Other behaviour can only be shown by the bench's scenarios. That covers which edge or level actually records a line under each sensitivity and polarity combination, the re-arming of a level line after an acknowledge, and the software trigger. It also covers the exact three-edge latency, the placement of lines across words (lines 0, 1, 37, 67 and 223), and the zero returned from alias, reserved and domain-1 addresses.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
   localparam int unsigned WORD_W    = 32;
   localparam int unsigned MAX_WORDS = 7;
   localparam int unsigned ADDR_W    = 12;
   localparam int unsigned NUM_CFG   = 4;

   typedef enum logic [3:0] {
      GRP_STAT   = 4'd0,
      GRP_ACK    = 4'd1,
      GRP_MASK   = 4'd2,
      GRP_MASK_S = 4'd3,
      GRP_MASK_C = 4'd4,
      GRP_SENS   = 4'd5,
      GRP_SENS_S = 4'd6,
      GRP_SENS_C = 4'd7,
      GRP_SOFT   = 4'd8,
      GRP_SOFT_S = 4'd9,
      GRP_SOFT_C = 4'd10,
      GRP_RSV_A  = 4'd11,
      GRP_POL    = 4'd12,
      GRP_POL_S  = 4'd13,
      GRP_POL_C  = 4'd14,
      GRP_RSV_B  = 4'd15
   } grp_e;

   // index of each configuration field inside the cfg array
   localparam int unsigned CF_MASK = 0;
   localparam int unsigned CF_SENS = 1;
   localparam int unsigned CF_SOFT = 2;
   localparam int unsigned CF_POL  = 3;

   // domain-0 enable window: addr[11:5] == this value
   localparam logic [6:0] EN0_PAGE = 7'b0100000;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] lvl_o,
   output logic [W-1:0] prev_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("xirq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain_q;
   logic [W-1:0]             prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[0] <= '0;
      else         chain_q[0] <= async_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) chain_q[s] <= '0;
         else         chain_q[s] <= chain_q[s-1];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= '0;
      else         prev_q <= chain_q[STAGES-1];
   end

   assign lvl_o  = chain_q[STAGES-1];
   assign prev_o = prev_q;
endmodule

// File: rtl/xirq_cfg.sv
module xirq_cfg #(
   parameter int unsigned   W    = 32,
   parameter logic [W-1:0]  KEEP = '1,
   parameter logic [W-1:0]  RST  = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] q;
   logic [W-1:0] set_k;
   logic [W-1:0] clr_k;

   assign set_k = set_i & KEEP;
   assign clr_k = clr_i & KEEP;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= RST & KEEP;
      else         q <= (q | set_k) & ~clr_k & KEEP;
   end

   assign q_o = q;

   // R3
   set_apply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|set_k && !(|clr_k)) |=> ((q & $past(set_k)) == $past(set_k)));

   // R4
   clr_apply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|clr_k && !(|set_k)) |=> ((q & $past(clr_k)) == '0));
endmodule

// File: rtl/xirq_pend.sv
module xirq_pend #(
   parameter int unsigned W = 32
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] lvl_i,
   input  logic [W-1:0] prev_i,
   input  logic [W-1:0] sens_i,
   input  logic [W-1:0] pol_i,
   input  logic [W-1:0] soft_i,
   input  logic [W-1:0] ack_i,
   output logic [W-1:0] pend_o
);
   logic [W-1:0] trig;
   logic [W-1:0] pend_q;

   for (genvar i = 0; i < W; i++) begin : g_line
      logic rise, fall, lvl_hit, edge_hit;
      assign rise     = lvl_i[i] & ~prev_i[i];
      assign fall     = ~lvl_i[i] & prev_i[i];
      assign lvl_hit  = ~(lvl_i[i] ^ pol_i[i]);
      assign edge_hit = pol_i[i] ? rise : fall;
      assign trig[i]  = soft_i[i] | (sens_i[i] ? lvl_hit : edge_hit);
   end

   // a trigger in the same cycle as an acknowledge wins
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q <= '0;
      else         pend_q <= (pend_q & ~ack_i) | trig;
   end

   assign pend_o = pend_q;

   // R8
   ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      |(ack_i & ~trig) |=> ((pend_q & $past(ack_i & ~trig)) == '0));

   // R8
   pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      |pend_q |=> (($past(pend_q) & ~$past(ack_i) & ~pend_q) == '0));
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
   import xirq_pkg::*;
#(
   parameter int unsigned NUM_LINES   = 224,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [NUM_LINES-1:0] line_i,
   input  logic                 wr_en_i,
   input  logic                 rd_en_i,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic [WORD_W-1:0]    wdata_i,
   output logic [WORD_W-1:0]    rdata_o,
   output logic                 irq_o
);
   localparam int unsigned WORDS = (NUM_LINES + WORD_W - 1) / WORD_W;
   localparam int unsigned PADW  = WORDS * WORD_W;
   localparam logic [3:0]  WORDS4 = 4'(WORDS);

   if (NUM_LINES < 1 || NUM_LINES > MAX_WORDS * WORD_W) begin : g_bad_lines
      $error("xirq_ctrl: NUM_LINES must be 1..224");
   end

   function automatic logic [PADW-1:0] mk_keep();
      logic [PADW-1:0] m;
      for (int i = 0; i < PADW; i++) m[i] = (i < NUM_LINES);
      return m;
   endfunction
   localparam logic [PADW-1:0] KEEP = mk_keep();

   function automatic logic [WORD_W-1:0] pick(input logic [PADW-1:0] v, input logic [3:0] idx);
      logic [WORD_W-1:0] r;
      r = '0;
      for (int w = 0; w < WORDS; w++) begin
         if (idx == 4'(w)) r = v[w*WORD_W +: WORD_W];
      end
      return r;
   endfunction

   // ---------------- address decode ----------------
   logic       aligned, grp_zone, en0_zone;
   logic [3:0] grp_idx;
   logic [3:0] word_idx;
   grp_e       grp;
   logic       grp_hit, en0_hit;

   assign aligned  = (addr_i[1:0] == 2'b00);
   assign grp_zone = (addr_i[11:10] == 2'b00);
   assign en0_zone = (addr_i[11:5] == EN0_PAGE);
   assign grp_idx  = addr_i[9:6];
   assign grp      = grp_e'(grp_idx);
   assign word_idx = grp_zone ? addr_i[5:2] : {1'b0, addr_i[4:2]};
   assign grp_hit  = aligned && grp_zone && (word_idx < WORDS4);
   assign en0_hit  = aligned && en0_zone && (word_idx < WORDS4);

   // write data spread across the line vector
   logic [PADW-1:0] wide;
   always_comb begin
      wide = '0;
      for (int w = 0; w < WORDS; w++) begin
         if (word_idx == 4'(w)) wide[w*WORD_W +: WORD_W] = wdata_i;
      end
   end

   logic gw;
   assign gw = wr_en_i && grp_hit;

   logic [NUM_CFG-1:0][PADW-1:0] set_v, clr_v, cfg_q;
   logic [PADW-1:0]              ack_v;

   assign ack_v              = (gw && grp == GRP_ACK)    ? wide : '0;
   assign set_v[CF_MASK]     = (gw && grp == GRP_MASK_S) ? wide : '0;
   assign clr_v[CF_MASK]     = (gw && grp == GRP_MASK_C) ? wide : '0;
   assign set_v[CF_SENS]     = (gw && grp == GRP_SENS_S) ? wide : '0;
   assign clr_v[CF_SENS]     = (gw && grp == GRP_SENS_C) ? wide : '0;
   assign set_v[CF_SOFT]     = (gw && grp == GRP_SOFT_S) ? wide : '0;
   assign clr_v[CF_SOFT]     = (gw && grp == GRP_SOFT_C) ? wide : '0;
   assign set_v[CF_POL]      = (gw && grp == GRP_POL_S)  ? wide : '0;
   assign clr_v[CF_POL]      = (gw && grp == GRP_POL_C)  ? wide : '0;

   // ---------------- configuration fields ----------------
   for (genvar c = 0; c < NUM_CFG; c++) begin : g_cfg
      localparam logic [PADW-1:0] RST_C = (c == CF_MASK) ? '1 : '0;
      xirq_cfg #(
         .W    (PADW),
         .KEEP (KEEP),
         .RST  (RST_C)
      ) u_cfg (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .set_i  (set_v[c]),
         .clr_i  (clr_v[c]),
         .q_o    (cfg_q[c])
      );
   end

   // ---------------- domain-0 enable (plain words) ----------------
   logic [PADW-1:0] en0_q;
   for (genvar w = 0; w < WORDS; w++) begin : g_en0
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            en0_q[w*WORD_W +: WORD_W] <= '0;
         else if (wr_en_i && en0_hit && word_idx == 4'(w))
            en0_q[w*WORD_W +: WORD_W] <= wdata_i & KEEP[w*WORD_W +: WORD_W];
      end
   end

   // ---------------- synchroniser and trigger ----------------
   logic [PADW-1:0] line_pad, lvl, prev, pend;
   assign line_pad = PADW'(line_i);

   xirq_sync #(
      .W      (PADW),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (line_pad),
      .lvl_o   (lvl),
      .prev_o  (prev)
   );

   xirq_pend #(
      .W (PADW)
   ) u_pend (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (lvl),
      .prev_i (prev),
      .sens_i (cfg_q[CF_SENS]),
      .pol_i  (cfg_q[CF_POL]),
      .soft_i (cfg_q[CF_SOFT]),
      .ack_i  (ack_v & KEEP),
      .pend_o (pend)
   );

   // ---------------- read path ----------------
   logic [WORD_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if (grp_hit) begin
         unique case (grp)
            GRP_STAT: rd_mux = pick(pend, word_idx);
            GRP_MASK: rd_mux = pick(cfg_q[CF_MASK], word_idx);
            GRP_SENS: rd_mux = pick(cfg_q[CF_SENS], word_idx);
            GRP_SOFT: rd_mux = pick(cfg_q[CF_SOFT], word_idx);
            GRP_POL:  rd_mux = pick(cfg_q[CF_POL], word_idx);
            default:  rd_mux = '0;
         endcase
      end else if (en0_hit) begin
         rd_mux = pick(en0_q, word_idx);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      rdata_o <= '0;
      else if (rd_en_i) rdata_o <= rd_mux;
   end

   // ---------------- aggregated interrupt ----------------
   assign irq_o = |(pend & ~cfg_q[CF_MASK] & en0_q);

   // R10
   irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en0_q == '0) |-> !irq_o);
endmodule

// File: tb/sim_xirq_ctrl.sv
`timescale 1ns/1ps
module sim_xirq_ctrl;
   localparam int NL = 224;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] lines = '0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [11:0]   addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          irq;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2.5 clk = ~clk;

   xirq_ctrl #(.NUM_LINES(NL)) u0 (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .line_i  (lines),
      .wr_en_i (wr_en),
      .rd_en_i (rd_en),
      .addr_i  (addr),
      .wdata_i (wdata),
      .rdata_o (rdata),
      .irq_o   (irq)
   );

   function automatic logic [11:0] ga(input int g, input int w);
      return 12'(g * 64 + w * 4);
   endfunction

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // driver: issue read, push expectation for the monitor
   task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   // monitor: data registered at the edge that saw rd_en
   initial begin
      forever begin
         @(posedge clk);
         if (rd_en) begin
            logic [31:0] e;
            string       t;
            @(negedge clk);
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            nchk++;
            if (rdata !== e) begin
               nerr++;
               $display("FAIL %s: rdata got %h expected %h", t, rdata, e);
            end
         end
      end
   end

   task automatic irq_now(input logic e, input string t);
      nchk++;
      if (irq !== e) begin
         nerr++;
         $display("FAIL %s: irq got %b expected %b", t, irq, e);
      end
   endtask

   task automatic chk_irq(input logic e, input string t);
      @(negedge clk);
      irq_now(e, t);
   endtask

   task automatic set_line(input int i, input logic v);
      @(negedge clk);
      lines[i] = v;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog: run got hung expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk_irq(1'b0, "R1 irq low");
      rd(ga(2, 0), 32'hFFFF_FFFF, "R1 mask w0");
      rd(ga(2, 6), 32'hFFFF_FFFF, "R1 mask w6");
      rd(ga(0, 0), 32'h0, "R1 status");
      rd(ga(5, 3), 32'h0, "R1 sens");
      rd(ga(12, 0), 32'h0, "R1 pol");
      rd(12'h400, 32'h0, "R1 d0en");

      // R3 / R4 on mask word 5 and polarity word 4
      wr(ga(4, 5), 32'h0000_00F0);
      rd(ga(2, 5), 32'hFFFF_FF0F, "R4 mask clear");
      wr(ga(3, 5), 32'h0000_0030);
      rd(ga(2, 5), 32'hFFFF_FF3F, "R3 mask set");
      wr(ga(3, 5), 32'h0);
      rd(ga(2, 5), 32'hFFFF_FF3F, "R3 zero bits");
      wr(ga(2, 5), 32'h0);
      rd(ga(2, 5), 32'hFFFF_FF3F, "R5 base write ignored");
      wr(ga(3, 5), 32'hFFFF_FFFF);
      rd(ga(2, 5), 32'hFFFF_FFFF, "R3 mask set all");
      wr(ga(13, 4), 32'h5);
      rd(ga(12, 4), 32'h5, "R3 pol set");
      wr(ga(14, 4), 32'h1);
      rd(ga(12, 4), 32'h4, "R4 pol clear");
      wr(ga(14, 4), 32'h4);
      rd(ga(12, 4), 32'h0, "R4 pol clear rest");

      // R5 zero reads and ignored locations
      rd(ga(3, 0), 32'h0, "R5 set alias reads 0");
      rd(ga(1, 0), 32'h0, "R5 ack reads 0");
      rd(ga(11, 0), 32'h0, "R5 reserved reads 0");
      wr(12'h420, 32'hFFFF_FFFF);
      rd(12'h420, 32'h0, "R5 domain-1 reads 0");
      rd(12'h41C, 32'h0, "R5 0x41C reads 0");
      wr(ga(0, 0), 32'hFFFF_FFFF);
      rd(ga(0, 0), 32'h0, "R5 status write ignored");

      // R6 falling edge on line 0
      set_line(0, 1'b1); idle(4);
      rd(ga(0, 0), 32'h0, "R6 rising ignored pol0");
      set_line(0, 1'b0); idle(4);
      rd(ga(0, 0), 32'h1, "R6 falling recorded");
      chk_irq(1'b0, "R10 masked no d0en");
      wr(12'h400, 32'h1);
      chk_irq(1'b0, "R10 still masked");
      wr(ga(4, 0), 32'h1);
      chk_irq(1'b1, "R10 routed and unmasked");
      wr(ga(1, 0), 32'hFFFF_FFFE);
      rd(ga(0, 0), 32'h1, "R8 ack zero bit no effect");
      wr(ga(1, 0), 32'h1);
      rd(ga(0, 0), 32'h0, "R8 ack clears");
      chk_irq(1'b0, "R8 irq drops");

      // R6 rising edge on line 37 (word 1 bit 5)
      wr(ga(13, 1), 32'h20);
      wr(12'h404, 32'h20);
      wr(ga(4, 1), 32'h20);
      set_line(37, 1'b1); idle(4);
      rd(ga(0, 1), 32'h20, "R6 R2 rising line 37");
      chk_irq(1'b1, "R10 line 37");
      idle(10);
      rd(ga(0, 1), 32'h20, "R8 edge held");
      wr(ga(1, 1), 32'h20); idle(4);
      rd(ga(0, 1), 32'h0, "R8 edge no rearm while high");
      chk_irq(1'b0, "R8 irq after ack");
      set_line(37, 1'b0); idle(4);
      rd(ga(0, 1), 32'h0, "R6 falling ignored pol1");

      // R7 level high on line 223 (word 6 bit 31)
      wr(ga(13, 6), 32'h8000_0000);
      wr(ga(6, 6), 32'h8000_0000);
      wr(ga(4, 6), 32'h8000_0000);
      wr(12'h418, 32'h8000_0000);
      idle(4);
      rd(ga(0, 6), 32'h0, "R7 inactive level");
      set_line(223, 1'b1); idle(4);
      rd(ga(0, 6), 32'h8000_0000, "R7 R2 high level line 223");
      chk_irq(1'b1, "R10 line 223");
      wr(ga(1, 6), 32'h8000_0000);
      rd(ga(0, 6), 32'h8000_0000, "R7 re-set while active");
      set_line(223, 1'b0); idle(4);
      rd(ga(0, 6), 32'h8000_0000, "R7 held after deassert");
      wr(ga(1, 6), 32'h8000_0000);
      rd(ga(0, 6), 32'h0, "R7 ack after deassert");
      chk_irq(1'b0, "R7 irq low");

      // R7 level low on line 1, plus gating
      wr(ga(6, 0), 32'h2); idle(4);
      rd(ga(0, 0), 32'h2, "R7 low level line 1");
      chk_irq(1'b0, "R10 pending but masked");
      wr(ga(4, 0), 32'h2);
      chk_irq(1'b0, "R10 not routed");
      wr(12'h400, 32'h3);
      chk_irq(1'b1, "R10 routed");
      wr(ga(3, 0), 32'h2);
      chk_irq(1'b0, "R10 remasked");
      rd(ga(2, 0), 32'hFFFF_FFFE, "R3 mask word 0");
      set_line(1, 1'b1); idle(4);
      wr(ga(1, 0), 32'h2);
      rd(ga(0, 0), 32'h0, "R7 clears once inactive");

      // R11 latency on line 0 (falling, routed, unmasked)
      set_line(0, 1'b1); idle(4);
      chk_irq(1'b0, "R11 idle before drop");
      lines[0] = 1'b0;
      @(negedge clk);
      @(negedge clk);
      irq_now(1'b0, "R11 not after two edges");
      @(negedge clk);
      irq_now(1'b1, "R11 after third edge");
      wr(ga(1, 0), 32'h1);
      chk_irq(1'b0, "R11 acked");

      // R9 software trigger on line 67 (word 2 bit 3)
      wr(ga(9, 2), 32'h8);
      rd(ga(8, 2), 32'h8, "R9 soft reads back");
      idle(2);
      rd(ga(0, 2), 32'h8, "R9 soft pends");
      chk_irq(1'b0, "R9 masked");
      wr(ga(4, 2), 32'h8);
      wr(12'h408, 32'h8);
      chk_irq(1'b1, "R9 soft raises irq");
      wr(ga(10, 2), 32'h8);
      wr(ga(1, 2), 32'h8);
      rd(ga(0, 2), 32'h0, "R9 soft cleared and acked");
      chk_irq(1'b0, "R9 irq low");

      wait (exp_q.size() == 0);
      idle(2);
      finish_run();
   end
endmodule